// File: doc/BRIEF.md
# Harvester Calibration and Flyback Sequencer

This block is the digital control unit of a capacitive vibration energy harvester. After reset, and then once per programmable period, it runs a calibration. First it holds the flyback switch closed with the pump stopped. This makes the lower threshold zero, so the storage node falls to the reservoir voltage. For a fixed number of millisecond ticks it enables the converter and records the reservoir code. It then starts the charge pump and watches the storage code rise. The first time two consecutive samples of that phase carry the same code, that code is taken as the saturation value. If no such pair appears within a bounded number of samples, the last sample is used instead and an error flag is raised.

From the reservoir code R and the saturation code S, with span D = S - R (zero when S is not above R), the block derives a low threshold R + floor(D/10) and a high threshold R + floor(6*D/10). A constant multiply-and-shift computes both in a single cycle. In normal operation the converter is switched off. The flyback switch then follows a separate storage-level code with hysteresis between the two thresholds, and the pump runs whenever the switch is open. The thresholds and the reservoir code stay in force until the next calibration; the saturation register reads zero.

Top module: `hvcal_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the block is in the hold phase: adc_en=1, flyback_on=1, pump_en=0, thr_valid=0, cal_err=0, thr_lo=thr_hi=ures=umax=0.
- R2: The hold phase keeps flyback_on=1, pump_en=0 and adc_en=1 for exactly HOLD_TICKS tick pulses. During it, every adc_valid loads adc_code into ures, so ures holds the last code sampled in the hold.
- R3: In the saturation phase pump_en=1, flyback_on=0 and adc_en=1. The phase ends on the first adc_valid whose code equals the previous sample of the same phase, and that code becomes the saturation value.
- R4: If TIMEOUT_SAMPLES samples arrive in the saturation phase with no equal consecutive pair, the last sample is the saturation value and cal_err=1. cal_err keeps its value through normal operation and clears when the next calibration starts.
- R5: One cycle after saturation is found, thr_valid=1, thr_lo = ures + floor(D/10) and thr_hi = ures + floor(6*D/10), where D = umax - ures when umax > ures and 0 otherwise.
- R6: While thr_valid=1 (normal operation) adc_en=0 and umax=0, and ures keeps the calibrated reservoir code.
- R7: In normal operation flyback_on becomes 1 on the cycle after store_lvl >= thr_hi. It becomes 0 on the cycle after store_lvl <= thr_lo, with the high test taking priority. Otherwise it holds its value. pump_en = !flyback_on at all times in this mode, and flyback_on starts at 0.
- R8: After cal_period tick pulses in normal operation (a value of 0 counts as 1), thr_valid falls and a new hold phase begins.
- R9: adc_valid pulses during normal operation are ignored: ures, thr_lo and thr_hi do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per millisecond |
| cal_period | input | PER_W | Ticks of normal operation between calibrations |
| adc_valid | input | 1 | Converter sample strobe |
| adc_code | input | CODE_W | Converter sample code |
| store_lvl | input | CODE_W | Storage-level code used in normal operation |
| adc_en | output | 1 | Converter enable |
| pump_en | output | 1 | Charge pump enable |
| flyback_on | output | 1 | Flyback switch drive |
| thr_lo | output | CODE_W | Lower storage threshold |
| thr_hi | output | CODE_W | Upper storage threshold |
| thr_valid | output | 1 | Thresholds valid, normal operation active |
| cal_err | output | 1 | Saturation timed out in the last calibration |
| ures | output | CODE_W | Measured reservoir code |
| umax | output | CODE_W | Measured saturation code, zero outside calibration |

## Verification
The assertions assume that store_lvl changes only between clock edges and that tick is a one-cycle pulse. They also assume that cal_period does not change while normal operation counts it. The bench generates tick from a free-running divider and holds cal_period constant. It drives adc_valid and store_lvl at falling edges, so each sample is seen by exactly one rising edge. It sends converter samples only after it has observed the phase they are meant for. The one exception is the normal-mode burst that R9 says must be ignored.

// File: rtl/hvcal_pkg.sv
package hvcal_pkg;
  typedef enum logic [1:0] {
    PH_HOLD = 2'd0,
    PH_SAT  = 2'd1,
    PH_CALC = 2'd2,
    PH_RUN  = 2'd3
  } phase_e;
endpackage

// File: rtl/hvcal_tick_cnt.sv
// Counts enabled tick pulses; done pulses on the pulse that reaches limit.
module hvcal_tick_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] last;

  assign last = limit - {{(W-1){1'b0}}, 1'b1};
  assign done = en && (cnt_q == last);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (done) cnt_d = '0;
    else if (en)   cnt_d = cnt_q + {{(W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/hvcal_satdet.sv
// Detects two equal consecutive samples, or a sample-count timeout.
module hvcal_satdet #(
  parameter int CODE_W  = 8,
  parameter int TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              smp_vld,
  input  logic [CODE_W-1:0] smp_code,
  output logic              found,
  output logic              tmo
);
  localparam int CW = $clog2(TIMEOUT + 1);

  logic [CODE_W-1:0] prev_q, prev_d;
  logic              have_q, have_d;
  logic [CW-1:0]     cnt_q, cnt_d;

  assign found = smp_vld && have_q && (smp_code == prev_q);
  assign tmo   = smp_vld && !found && (cnt_q == CW'(TIMEOUT - 1));

  always_comb begin
    prev_d = prev_q;
    have_d = have_q;
    cnt_d  = cnt_q;
    if (clr) begin
      have_d = 1'b0;
      cnt_d  = '0;
    end else if (smp_vld) begin
      prev_d = smp_code;
      have_d = 1'b1;
      cnt_d  = cnt_q + {{(CW-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      have_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= prev_d;
      have_q <= have_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/hvcal_frac.sv
// Threshold arithmetic: base + floor(span/10) and base + floor(6*span/10).
// Division by ten is a multiply by ceil(2^19/10) and a shift by 19, which
// is exact for dividends below 43690 (CODE_W up to 12).
module hvcal_frac #(
  parameter int CODE_W = 8
) (
  input  logic [CODE_W-1:0] base,
  input  logic [CODE_W-1:0] top,
  output logic [CODE_W-1:0] lo,
  output logic [CODE_W-1:0] hi
);
  localparam int XW    = CODE_W + 3;
  localparam int SH    = 19;
  localparam int RW    = 16;
  localparam int PW    = XW + RW;
  localparam logic [RW-1:0] RECIP = RW'(((1 << SH) + 9) / 10);

  logic [CODE_W-1:0] span;
  logic [XW-1:0]     x1, x6;
  logic [PW-1:0]     p1, p6;
  logic [CODE_W-1:0] q1, q6;

  assign span = (top > base) ? (top - base) : '0;
  assign x1   = {3'b000, span};
  assign x6   = (x1 << 2) + (x1 << 1);
  assign p1   = {{RW{1'b0}}, x1} * {{XW{1'b0}}, RECIP};
  assign p6   = {{RW{1'b0}}, x6} * {{XW{1'b0}}, RECIP};
  assign q1   = CODE_W'(p1 >> SH);
  assign q6   = CODE_W'(p6 >> SH);
  assign lo   = base + q1;
  assign hi   = base + q6;
endmodule

// File: rtl/hvcal_hyst.sv
// Flyback switch with hysteresis between two thresholds.
module hvcal_hyst #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CODE_W-1:0] lvl,
  input  logic [CODE_W-1:0] lo,
  input  logic [CODE_W-1:0] hi,
  output logic              sw
);
  logic sw_d;

  always_comb begin
    sw_d = sw;
    if (!en)             sw_d = 1'b0;
    else if (lvl >= hi)  sw_d = 1'b1;
    else if (lvl <= lo)  sw_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw <= 1'b0;
    else        sw <= sw_d;
  end
endmodule

// File: rtl/hvcal_seq.sv
module hvcal_seq
  import hvcal_pkg::*;
#(
  parameter int CODE_W          = 8,
  parameter int PER_W           = 16,
  parameter int HOLD_TICKS      = 20,
  parameter int TIMEOUT_SAMPLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [PER_W-1:0]  cal_period,
  input  logic              adc_valid,
  input  logic [CODE_W-1:0] adc_code,
  input  logic [CODE_W-1:0] store_lvl,
  output logic              adc_en,
  output logic              pump_en,
  output logic              flyback_on,
  output logic [CODE_W-1:0] thr_lo,
  output logic [CODE_W-1:0] thr_hi,
  output logic              thr_valid,
  output logic              cal_err,
  output logic [CODE_W-1:0] ures,
  output logic [CODE_W-1:0] umax
);
  localparam int HW = $clog2(HOLD_TICKS + 1);

  phase_e phase_q, phase_d;
  logic   in_hold, in_sat, in_calc, in_run;
  logic   hold_done, per_done, sat_found, sat_tmo, sat_end;
  logic   sw;
  logic [PER_W-1:0]  per_lim;
  logic [CODE_W-1:0] lo_calc, hi_calc;

  logic [CODE_W-1:0] ures_q, ures_d, umax_q, umax_d;
  logic [CODE_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic              vld_q, vld_d, err_q, err_d;

  assign in_hold = (phase_q == PH_HOLD);
  assign in_sat  = (phase_q == PH_SAT);
  assign in_calc = (phase_q == PH_CALC);
  assign in_run  = (phase_q == PH_RUN);
  assign per_lim = (cal_period == '0) ? {{(PER_W-1){1'b0}}, 1'b1} : cal_period;
  assign sat_end = sat_found || sat_tmo;

  hvcal_tick_cnt #(.W(HW)) u_hold_cnt (
    .clk(clk), .rst_n(rst_n), .clr(!in_hold), .en(tick && in_hold),
    .limit(HW'(HOLD_TICKS)), .done(hold_done)
  );

  hvcal_tick_cnt #(.W(PER_W)) u_per_cnt (
    .clk(clk), .rst_n(rst_n), .clr(!in_run), .en(tick && in_run),
    .limit(per_lim), .done(per_done)
  );

  hvcal_satdet #(.CODE_W(CODE_W), .TIMEOUT(TIMEOUT_SAMPLES)) u_satdet (
    .clk(clk), .rst_n(rst_n), .clr(!in_sat), .smp_vld(adc_valid && in_sat),
    .smp_code(adc_code), .found(sat_found), .tmo(sat_tmo)
  );

  hvcal_frac #(.CODE_W(CODE_W)) u_frac (
    .base(ures_q), .top(umax_q), .lo(lo_calc), .hi(hi_calc)
  );

  hvcal_hyst #(.CODE_W(CODE_W)) u_hyst (
    .clk(clk), .rst_n(rst_n), .en(in_run), .lvl(store_lvl),
    .lo(lo_q), .hi(hi_q), .sw(sw)
  );

  // Phase sequencing
  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_HOLD: if (hold_done) phase_d = PH_SAT;
      PH_SAT:  if (sat_end)   phase_d = PH_CALC;
      PH_CALC:                phase_d = PH_RUN;
      PH_RUN:  if (per_done)  phase_d = PH_HOLD;
      default:                phase_d = PH_HOLD;
    endcase
  end

  // Measurement and threshold registers
  always_comb begin
    ures_d = ures_q;
    umax_d = umax_q;
    lo_d   = lo_q;
    hi_d   = hi_q;
    vld_d  = vld_q;
    err_d  = err_q;
    if (in_hold && adc_valid) ures_d = adc_code;
    if (in_sat && sat_end)    umax_d = adc_code;
    if (in_sat && sat_tmo)    err_d  = 1'b1;
    if (in_calc) begin
      lo_d   = lo_calc;
      hi_d   = hi_calc;
      vld_d  = 1'b1;
      umax_d = '0;
    end
    if (in_run && per_done) begin
      vld_d = 1'b0;
      err_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_HOLD;
      ures_q  <= '0;
      umax_q  <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      vld_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      ures_q  <= ures_d;
      umax_q  <= umax_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
      vld_q   <= vld_d;
      err_q   <= err_d;
    end
  end

  assign adc_en     = in_hold || in_sat;
  assign pump_en    = in_sat || (in_run && !sw);
  assign flyback_on = in_hold || (in_run && sw);
  assign thr_lo     = lo_q;
  assign thr_hi     = hi_q;
  assign thr_valid  = vld_q;
  assign cal_err    = err_q;
  assign ures       = ures_q;
  assign umax       = umax_q;
endmodule

// File: rtl/hvcal_seq_chk.sv
module hvcal_seq_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adc_valid,
  input logic [CODE_W-1:0] store_lvl,
  input logic              adc_en,
  input logic              pump_en,
  input logic              flyback_on,
  input logic [CODE_W-1:0] thr_lo,
  input logic [CODE_W-1:0] thr_hi,
  input logic              thr_valid,
  input logic              cal_err,
  input logic [CODE_W-1:0] ures,
  input logic [CODE_W-1:0] umax
);
  assert_no_adc_in_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    thr_valid |-> (!adc_en && umax == '0));

  assert_no_shoot_through_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(flyback_on && pump_en));

  assert_thr_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    thr_valid |-> (thr_lo <= thr_hi && thr_lo >= ures));

  assert_fly_on_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_valid && $past(thr_valid) && $rose(flyback_on)) |-> ($past(store_lvl) >= $past(thr_hi)));

  assert_fly_off_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_valid && $past(thr_valid) && $fell(flyback_on)) |-> ($past(store_lvl) <= $past(thr_lo)));

  assert_run_state_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_valid && $past(thr_valid)) |-> ($stable(ures) && $stable(thr_lo) && $stable(thr_hi)));

  assert_err_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_valid && $past(thr_valid)) |-> $stable(cal_err));

  assert_sat_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_en && pump_en) |-> !flyback_on);
endmodule

bind hvcal_seq hvcal_seq_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_valid(adc_valid), .store_lvl(store_lvl),
  .adc_en(adc_en), .pump_en(pump_en), .flyback_on(flyback_on),
  .thr_lo(thr_lo), .thr_hi(thr_hi), .thr_valid(thr_valid),
  .cal_err(cal_err), .ures(ures), .umax(umax)
);

// File: tb/hvcal_seq_bench.sv
module hvcal_seq_bench;
  localparam int CW   = 8;
  localparam int PW   = 16;
  localparam int HOLD = 20;
  localparam int TMO  = 64;
  localparam int PER  = 30;

  typedef struct {
    int lo;
    int hi;
    int err;
    int ur;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [1:0]    tdiv = 2'd0;
  logic [PW-1:0] cal_period = PW'(PER);
  logic          adc_valid = 1'b0;
  logic [CW-1:0] adc_code = '0;
  logic [CW-1:0] store_lvl = '0;
  logic          adc_en, pump_en, flyback_on, thr_valid, cal_err;
  logic [CW-1:0] thr_lo, thr_hi, ures, umax;

  int   n_run = 0;
  int   n_fail = 0;
  exp_t exp_q[$];

  hvcal_seq #(.CODE_W(CW), .PER_W(PW), .HOLD_TICKS(HOLD), .TIMEOUT_SAMPLES(TMO)) u_hvcal_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cal_period(cal_period),
    .adc_valid(adc_valid), .adc_code(adc_code), .store_lvl(store_lvl),
    .adc_en(adc_en), .pump_en(pump_en), .flyback_on(flyback_on),
    .thr_lo(thr_lo), .thr_hi(thr_hi), .thr_valid(thr_valid),
    .cal_err(cal_err), .ures(ures), .umax(umax)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    tdiv <= tdiv + 2'd1;
    tick <= (tdiv == 2'd3);
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Scoreboard monitor: compares each new threshold set against the queue
  logic prev_vld = 1'b0;
  always @(negedge clk) begin
    if (rst_n && thr_valid && !prev_vld) begin
      if (exp_q.size() == 0) begin
        chk("R5 unexpected thresholds", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R5 thr_lo", int'(thr_lo), e.lo);
        chk("R5 thr_hi", int'(thr_hi), e.hi);
        chk("R4 cal_err", int'(cal_err), e.err);
        chk("R2 ures", int'(ures), e.ur);
        chk("R6 umax cleared", int'(umax), 0);
        chk("R6 adc_en off", int'(adc_en), 0);
      end
    end
    prev_vld <= thr_valid;
  end

  // Hold length (R2) and period (R8) monitors, counted in tick pulses
  int   hold_n = 0;
  int   per_n = 0;
  logic prev_sat = 1'b0;
  logic prev_adc = 1'b1;
  logic seen_run = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (adc_en && flyback_on && !pump_en && tick) hold_n++;
      if (adc_en && pump_en && !prev_sat) begin
        chk("R2 hold ticks", hold_n, HOLD);
        chk("R3 flyback off in saturation phase", int'(flyback_on), 0);
        hold_n = 0;
      end
      if (thr_valid && tick) per_n++;
      if (thr_valid) seen_run = 1'b1;
      if (adc_en && !prev_adc && seen_run) begin
        chk("R8 period ticks", per_n, PER);
        chk("R8 thr_valid dropped", int'(thr_valid), 0);
        chk("R4 cal_err cleared", int'(cal_err), 0);
        per_n = 0;
      end
      prev_sat <= adc_en && pump_en;
      prev_adc <= adc_en;
    end
  end

  task automatic sample(input int code);
    @(negedge clk);
    adc_valid = 1'b1;
    adc_code  = CW'(code);
    @(negedge clk);
    adc_valid = 1'b0;
  endtask

  function automatic exp_t model(input int ur, input int um, input int err);
    exp_t e;
    int d;
    d = (um > ur) ? um - ur : 0;
    e.lo = ur + d / 10;
    e.hi = ur + (d * 6) / 10;
    e.err = err;
    e.ur = ur;
    return e;
  endfunction

  // Driver: pushes expectation, then plays a hold and a saturation phase
  task automatic run_cal(input int h0, input int h1, input int sat[$], input int um, input int err);
    exp_q.push_back(model(h1, um, err));
    while (!(adc_en && flyback_on && !pump_en)) @(negedge clk);
    sample(h0);
    sample(h1);
    while (!(adc_en && pump_en)) @(negedge clk);
    foreach (sat[i]) sample(sat[i]);
    while (!thr_valid) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int sq[$];
    repeat (3) @(negedge clk);
    chk("R1 adc_en in reset", int'(adc_en), 1);
    chk("R1 flyback in reset", int'(flyback_on), 1);
    chk("R1 pump in reset", int'(pump_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 thr_valid after reset", int'(thr_valid), 0);
    chk("R1 cal_err after reset", int'(cal_err), 0);
    chk("R1 thresholds after reset", int'(thr_lo) + int'(thr_hi) + int'(umax), 0);

    // Calibration 1: settles on 120, reservoir 50
    store_lvl = 8'd70;
    sq = '{60, 90, 120, 120};
    run_cal(40, 50, sq, 120, 0);
    // R7 hysteresis between 57 and 92
    chk("R7 switch open at mid level", int'(flyback_on), 0);
    chk("R7 pump on at mid level", int'(pump_en), 1);
    store_lvl = 8'd92; @(negedge clk);
    chk("R7 switch closes at hi", int'(flyback_on), 1);
    chk("R7 pump off while closed", int'(pump_en), 0);
    store_lvl = 8'd70; @(negedge clk);
    chk("R7 switch holds inside window", int'(flyback_on), 1);
    store_lvl = 8'd57; @(negedge clk);
    chk("R7 switch opens at lo", int'(flyback_on), 0);
    store_lvl = 8'd91; @(negedge clk);
    chk("R7 stays open below hi", int'(flyback_on), 0);
    store_lvl = 8'd0;
    // R9 samples in normal operation are ignored
    sample(255);
    sample(255);
    chk("R9 ures unchanged", int'(ures), 50);
    chk("R9 thr_lo unchanged", int'(thr_lo), 57);
    chk("R9 thr_hi unchanged", int'(thr_hi), 92);

    // Calibration 2: reservoir 100, saturation 250
    sq = '{110, 150, 200, 230, 250, 250};
    run_cal(90, 100, sq, 250, 0);

    // Calibration 3: no repeat within timeout, R4
    sq.delete();
    for (int i = 0; i < TMO; i++) sq.push_back(20 + i);
    run_cal(5, 10, sq, 20 + TMO - 1, 1);

    // Calibration 4: saturation below reservoir, span clamps to zero (R5)
    sq = '{150, 150};
    run_cal(210, 200, sq, 150, 0);

    chk("R5 scoreboard drained", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule